// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A port controller for a bank of general-purpose pins, accessed over a simple single-cycle register bus. Software sets each pin's output value and whether the pin drives, reads back the pad levels after synchronisation, and arms per-pin interrupt detection. A pin's detector can watch for either edge direction or either active level. Detected events latch into sticky status bits. The status bits and a per-pin enable together drive a combined interrupt line. Optionally the upper half of the pins gets a line of its own.

Every control register can be reached at three aliases: one overwrites it, one ORs in the written ones, and one clears the written ones. This lets two agents change separate pins without a read-modify-write race. A per-pin source gate decides whether a pin's detector may set status at all. A separate enable decides whether latched status reaches the interrupt output. Status can only be cleared through its clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, pad_o, pad_oe_o, irq_o and irq_hi_o are 0, and rdata_o is 0.
- R2: Register index is addr_i[7:4]: 0 output data, 1 output enable, 2 input data, 3 source gate, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Access type is addr_i[3:2]. A write at 0 overwrites a control register, a write at 1 ORs wdata_i into it, a write at 2 clears the bits set in wdata_i, and a write at 3 changes nothing. A read at any access type returns the register value.
- R3: pad_o equals the output-data register and pad_oe_o equals the output-enable register, from the cycle after the write.
- R4: The input-data register returns pad_i after a two-flop synchroniser. Writes to it have no effect.
- R5: A pin with level select 0 is edge-sensitive. Polarity 1 detects a rising edge and polarity 0 a falling edge. The status bit is set on the third clock edge after the pad change.
- R6: A pin with level select 1 is level-sensitive. Polarity 1 means active high and 0 means active low. Status is set again on every cycle the level is active, so a clear has no lasting effect until the level goes away.
- R7: A pin whose source-gate bit is 0 never sets its status bit.
- R8: A status bit clears only when 1 is written to its position with access type 2. Writes at access types 0 and 1 leave status unchanged. A detected event in the same cycle as a clear leaves the bit set.
- R9: A pin raises the interrupt only when its status and enable bits are both 1. A pin with enable 0 still latches status.
- R10: With SPLIT_IRQ=1, irq_o is the OR over pins 0..15 and irq_hi_o the OR over pins 16..31. With SPLIT_IRQ=0, irq_o covers all pins and irq_hi_o stays 0.
- R11: Read data appears on rdata_o one clock after a read request. A read of register index 8 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte address: index, access type |
| wdata_i | input | NPIN | Write data |
| rdata_o | output | NPIN | Registered read data |
| pad_i | input | NPIN | Pad levels, asynchronous |
| pad_o | output | NPIN | Pad output values |
| pad_oe_o | output | NPIN | Pad drive enables |
| irq_o | output | 1 | Interrupt, all pins or lower half |
| irq_hi_o | output | 1 | Interrupt, upper half |

## Verification
A detected event and a status clear can land on the same clock edge, and the bit must then stay set. The bench places a rising pad edge so that its event is registered on exactly the edge that applies a clear-alias write. It then reads the status back and expects the bit set. Repeating the clear one cycle later, with no event present, must leave the bit at zero. The same collision is also provoked with an active level, where a clear written during the level has to be overridden on the following cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_SET = 2'd1,
    ACC_CLR = 2'd2,
    ACC_NOP = 2'd3
  } acc_e;

  localparam int unsigned REG_DOUT = 0;
  localparam int unsigned REG_OE   = 1;
  localparam int unsigned REG_DIN  = 2;
  localparam int unsigned REG_SRC  = 3;
  localparam int unsigned REG_EN   = 4;
  localparam int unsigned REG_LVL  = 5;
  localparam int unsigned REG_POL  = 6;
  localparam int unsigned REG_STAT = 7;
  localparam int unsigned NUM_REGS = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl_hit, rise, fall;
    assign lvl_hit  = (pin_i[i] == pol_i[i]);
    assign rise     = pin_i[i] & ~prev_q[i];
    assign fall     = ~pin_i[i] & prev_q[i];
    assign evt_o[i] = src_i[i] & (lvl_i[i] ? lvl_hit : (pol_i[i] ? rise : fall));
  end
endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  acc_e         acc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_i) begin
      unique case (acc_i)
        ACC_RW:  q_o <= wdata_i;
        ACC_SET: q_o <= q_o | wdata_i;
        ACC_CLR: q_o <= q_o & ~wdata_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN        = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SPLIT_IRQ   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic              irq_o,
  output logic              irq_hi_o
);
  localparam int unsigned IDX_LSB = 4;
  localparam int unsigned IDX_W   = ADDR_W - IDX_LSB;
  localparam int unsigned SEL_W   = $clog2(NUM_REGS);
  localparam int unsigned HALF    = NPIN / 2;

  logic [IDX_W-1:0]               idx;
  acc_e                           acc;
  logic                           wr;
  logic [NUM_REGS-1:0][NPIN-1:0]  bank;
  logic [NPIN-1:0]                pin_s, evt, clr_mask, pend;
  logic [NPIN-1:0]                stat_q, src_q, en_q;
  logic                           unused_addr;

  assign idx         = addr_i[ADDR_W-1:IDX_LSB];
  assign acc         = acc_e'(addr_i[3:2]);
  assign wr          = req_i & we_i;
  assign unused_addr = ^addr_i[1:0];

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_s)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == REG_DIN) begin : g_din
      assign bank[g] = pin_s;
    end else if (g == REG_STAT) begin : g_stat
      assign bank[g] = stat_q;
    end else begin : g_ctrl
      gpio_ctrl_reg #(.W(NPIN)) i_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr && (idx == IDX_W'(g))),
        .acc_i  (acc),
        .wdata_i(wdata_i),
        .q_o    (bank[g])
      );
    end
  end

  assign src_q    = bank[REG_SRC];
  assign en_q     = bank[REG_EN];
  assign pad_o    = bank[REG_DOUT];
  assign pad_oe_o = bank[REG_OE];

  gpio_irq_detect #(.W(NPIN)) i_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_s),
    .src_i (src_q),
    .lvl_i (bank[REG_LVL]),
    .pol_i (bank[REG_POL]),
    .evt_o (evt)
  );

  // clear alias only; a same-cycle event wins
  assign clr_mask = (wr && idx == IDX_W'(REG_STAT) && acc == ACC_CLR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i)
      rdata_o <= (idx < IDX_W'(NUM_REGS)) ? bank[idx[SEL_W-1:0]] : '0;
  end

  assign pend = stat_q & en_q;

  if (SPLIT_IRQ) begin : g_split
    assign irq_o    = |pend[HALF-1:0];
    assign irq_hi_o = |pend[NPIN-1:HALF];
  end else begin : g_flat
    assign irq_o    = |pend;
    assign irq_hi_o = 1'b0;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPIN-1:0]   wdata_i,
  input logic [NPIN-1:0]   rdata_o,
  input logic [NPIN-1:0]   pad_o,
  input logic [NPIN-1:0]   pad_oe_o,
  input logic              irq_o,
  input logic              irq_hi_o,
  input logic [NPIN-1:0]   stat_q,
  input logic [NPIN-1:0]   src_q,
  input logic [NPIN-1:0]   en_q
);
  localparam int unsigned IDX_LSB = 4;
  localparam int unsigned IDX_W   = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0] idx;
  logic [1:0]       acc;
  logic             wr_dout_rw, wr_nop, stat_clr, rd_unmapped, unused_addr;

  assign idx         = addr_i[ADDR_W-1:IDX_LSB];
  assign acc         = addr_i[3:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr_dout_rw  = req_i && we_i && idx == '0 && acc == 2'd0;
  assign wr_nop      = req_i && we_i && acc == 2'd3;
  assign stat_clr    = req_i && we_i && idx == IDX_W'(7) && acc == 2'd2;
  assign rd_unmapped = req_i && !we_i && idx >= IDX_W'(8);

  // R3
  dout_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dout_rw |=> pad_o == $past(wdata_i));

  // R2
  nop_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_nop |=> $stable(pad_o) && $stable(pad_oe_o));

  // R8
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R7
  src_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(src_q)) == '0);

  // R9
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o && !irq_hi_o);

  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |=> rdata_o == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .irq_o   (irq_o),
  .irq_hi_o(irq_hi_o),
  .stat_q  (stat_q),
  .src_q   (src_q),
  .en_q    (en_q)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pad = '0;
  logic [31:0] rdata, pad_o, pad_oe, rdata_f, pad_o_f, pad_oe_f;
  logic        irq, irq_hi, irq_f, irq_hi_f;
  logic [31:0] rd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq), .irq_hi_o(irq_hi));

  gpio_irq_port #(.SPLIT_IRQ(1'b0)) i_gpio_irq_port_flat (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_f), .pad_i(pad), .pad_o(pad_o_f),
    .pad_oe_o(pad_oe_f), .irq_o(irq_f), .irq_hi_o(irq_hi_f));

  // {is_read, addr, data}
  localparam int NV = 14;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hA5A5_0F0F}, {1'b1, 8'h00, 32'hA5A5_0F0F},
    {1'b0, 8'h04, 32'h0000_F000}, {1'b1, 8'h00, 32'hA5A5_FF0F},
    {1'b0, 8'h08, 32'hA000_000F}, {1'b1, 8'h00, 32'h05A5_FF00},
    {1'b0, 8'h0C, 32'hFFFF_FFFF}, {1'b1, 8'h00, 32'h05A5_FF00},
    {1'b0, 8'h10, 32'h1234_5678}, {1'b1, 8'h14, 32'h1234_5678},
    {1'b0, 8'h20, 32'hFFFF_FFFF}, {1'b1, 8'h20, 32'h0000_0000},
    {1'b0, 8'h80, 32'hFFFF_FFFF}, {1'b1, 8'h88, 32'h0000_0000}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk(rdata, 32'h0, "R1 rdata");
    chk(pad_o, 32'h0, "R1 pad_o");
    chk(pad_oe, 32'h0, "R1 pad_oe");
    chk({31'h0, irq | irq_hi | irq_f}, 32'h0, "R1 irq");
    for (int k = 0; k < 8; k++) begin
      bus_read(8'(k * 16), rd);
      chk(rd, 32'h0, "R1 register");
    end

    // vector walk: aliases, input-data write, unmapped index
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) begin
        bus_read(VEC[v][39:32], rd);
        if (VEC[v][39:36] == 4'h2)      chk(rd, VEC[v][31:0], "R4 vector");
        else if (VEC[v][39:36] >= 4'h8) chk(rd, VEC[v][31:0], "R11 vector");
        else                            chk(rd, VEC[v][31:0], "R2 vector");
      end else begin
        bus_write(VEC[v][39:32], VEC[v][31:0]);
      end
    end
    chk(pad_o, 32'h05A5_FF00, "R3 pad_o");
    chk(pad_oe, 32'h1234_5678, "R3 pad_oe");

    // R4 synchroniser latency
    set_pad(32'hDEAD_BEEF);
    bus_read(8'h20, rd);
    chk(rd, 32'h0, "R4 din before sync");
    idle(3);
    bus_read(8'h20, rd);
    chk(rd, 32'hDEAD_BEEF, "R4 din after sync");
    set_pad(32'h0);
    idle(4);
    bus_read(8'h70, rd);
    chk(rd, 32'h0, "R7 ungated pins latch nothing");

    // R5 edges: pin0 and pin20 rising, pin1 falling
    bus_write(8'h60, 32'h0010_0001);
    bus_write(8'h30, 32'h0010_0003);
    set_pad(32'h3);
    idle(4);
    bus_read(8'h70, rd);
    chk(rd, 32'h1, "R5 rising only");
    set_pad(32'h0);
    idle(4);
    bus_read(8'h70, rd);
    chk(rd, 32'h3, "R5 falling added");

    // R9 enable gating
    chk({31'h0, irq}, 32'h0, "R9 masked pins silent");
    bus_write(8'h40, 32'h0010_0002);
    chk({31'h0, irq}, 32'h1, "R10 low line");
    chk({31'h0, irq_hi}, 32'h0, "R10 high line idle");
    chk({31'h0, irq_f}, 32'h1, "R10 flat line");

    // R8 status write protection
    bus_write(8'h70, 32'h0);
    bus_write(8'h74, 32'hFFFF_FFFF);
    bus_read(8'h70, rd);
    chk(rd, 32'h3, "R8 rw/set alias ignored");
    bus_write(8'h78, 32'h2);
    bus_read(8'h70, rd);
    chk(rd, 32'h1, "R8 clear one bit");
    chk({31'h0, irq}, 32'h0, "R9 latched but not enabled");
    bus_write(8'h78, 32'h1);

    // R10 upper half
    set_pad(32'h0010_0000);
    idle(4);
    chk({31'h0, irq_hi}, 32'h1, "R10 high line");
    chk({31'h0, irq}, 32'h0, "R10 low line idle");
    chk({31'h0, irq_f}, 32'h1, "R10 flat covers upper");
    set_pad(32'h0);
    bus_write(8'h78, 32'h0010_0000);
    chk({31'h0, irq_hi | irq_f}, 32'h0, "R10 cleared");

    // R6 high level on pin5
    bus_write(8'h64, 32'h20);
    bus_write(8'h54, 32'h20);
    bus_write(8'h34, 32'h20);
    set_pad(32'h20);
    idle(4);
    bus_write(8'h78, 32'h20);
    bus_read(8'h70, rd);
    chk(rd, 32'h20, "R6 level re-sets after clear");
    set_pad(32'h0);
    idle(4);
    bus_write(8'h78, 32'h20);
    bus_read(8'h70, rd);
    chk(rd, 32'h0, "R6 clear once level gone");

    // R6 low level on pin6: arming with pad low sets status
    bus_write(8'h54, 32'h40);
    bus_write(8'h34, 32'h40);
    idle(2);
    bus_read(8'h70, rd);
    chk(rd, 32'h40, "R6 active low");
    set_pad(32'h40);
    idle(4);
    bus_write(8'h78, 32'h40);
    bus_read(8'h70, rd);
    chk(rd, 32'h0, "R6 low level released");
    bus_write(8'h38, 32'h40);

    // R8 event and clear on the same edge (pin0 rising)
    set_pad(32'h41);
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h78; wdata = 32'h1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    bus_read(8'h70, rd);
    chk(rd, 32'h1, "R8 event beats clear");
    bus_write(8'h78, 32'h1);
    bus_read(8'h70, rd);
    chk(rd, 32'h0, "R8 later clear succeeds");

    finish_run();
  end
endmodule